// File: doc/BRIEF.md
# Bus Phase Sequencer with Shared Delay Timer

This block paces the three timed phases of a two-wire serial bus transaction: setup, hold and stop. It starts in an idle state that also arms the first delay. When a start request arrives, it runs the three phases in a fixed order and raises a one-cycle completion flag before it goes back to idle. One down-counter times all three phases. Each arming state writes its phase's delay into that counter on the same clock edge that moves the state machine into the matching wait state. Because the load and the transition share one edge, no wait state ever sees a stale zero left over from an earlier phase. This holds even for a zero-length delay.

The delays come in as three input ports. Each one is sampled only on the edge that loads it. Everything is synchronous to the rising clock edge, and that includes reset. Bus pin driving, clock stretching and arbitration belong to neighbouring logic.

Top module: `bus_phase_seq`

## Requirements
- R1: A high `rst` at a rising edge puts the sequencer into IDLE (state code 0) with the timer at 0 and `done` low. This holds at any point of a running sequence.
- R2: In IDLE, a high `startReq` at an edge moves the state to WAIT_SETUP (code 1) and loads `setupDelay` into the timer on that same edge. While `startReq` is low, the state stays at IDLE.
- R3: A wait state (WAIT_SETUP 1, WAIT_HOLD 3, WAIT_STOP 5) entered with delay N lasts exactly N+1 cycles. It leaves on the first edge at which the timer reads 0, so a delay of 0 gives a one-cycle wait.
- R4: When no load happens, the timer falls by exactly one per cycle while it is above 0 and stays at 0 once it gets there.
- R5: The arming states ARM_HOLD (2) and ARM_STOP (4) each last one cycle. On the edge that leaves an arming state, `holdDelay` or `stopDelay` respectively is loaded into the shared timer, and the state moves to the next wait state. A load takes priority over the decrement.
- R6: After WAIT_STOP the state becomes FINISH (code 6) for exactly one cycle with `done` high. The state then returns to IDLE, and `done` is low in every other state.
- R7: A delay input that changes after its load edge has no effect on the timer or on the length of the phase already running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| startReq | input | 1 | Request to start a transaction sequence |
| setupDelay | input | TIMER_W | Extra cycles of the setup phase |
| holdDelay | input | TIMER_W | Extra cycles of the hold phase |
| stopDelay | input | TIMER_W | Extra cycles of the stop phase |
| seqState | output | 3 | Current state code |
| done | output | 1 | High for the one FINISH cycle |
| timerVal | output | TIMER_W | Current value of the shared down-counter |

## Verification
Every result is due one edge after the stimulus that causes it. A start sampled at edge k shows WAIT_SETUP with the setup delay in the timer just after edge k. Each later value then follows one cycle at a time: setup takes a+1 cycles, arming takes 1, hold takes b+1, arming takes 1, stop takes c+1, and FINISH takes 1.

The driver pushes this whole per-cycle trace into a queue in the cycle before the start edge. The monitor pops one entry shortly after each rising edge and compares state, timer and `done`. In this way every comparison falls in the cycle the requirement names, and a wait that is one cycle short or one cycle long misaligns everything after it.

A bench model that uses a separate set/expired handshake runs alongside the block. It shows the early exit on a short delay that the shared-edge load avoids.

// File: rtl/seq_pkg.sv
package seq_pkg;

  localparam int NUM_PHASES = 3;
  localparam int SEL_W = $clog2(NUM_PHASES);

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_WAIT_SETUP = 3'd1,
    ST_ARM_HOLD   = 3'd2,
    ST_WAIT_HOLD  = 3'd3,
    ST_ARM_STOP   = 3'd4,
    ST_WAIT_STOP  = 3'd5,
    ST_FINISH     = 3'd6
  } seq_state_e;

  typedef enum logic [SEL_W-1:0] {
    PH_SETUP = 2'd0,
    PH_HOLD  = 2'd1,
    PH_STOP  = 2'd2
  } phase_sel_e;

  typedef struct packed {
    logic       load;
    phase_sel_e sel;
  } timer_strb_t;

endpackage

// File: rtl/seq_timer_dp.sv
module seq_timer_dp
  import seq_pkg::*;
#(
  parameter int TIMER_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  timer_strb_t        strb,
  input  logic [TIMER_W-1:0] setupDelay,
  input  logic [TIMER_W-1:0] holdDelay,
  input  logic [TIMER_W-1:0] stopDelay,
  output logic [TIMER_W-1:0] timerVal,
  output logic               timerZero
);

  localparam logic [TIMER_W-1:0] ONE  = TIMER_W'(1);
  localparam logic [TIMER_W-1:0] ZERO = '0;

  logic [TIMER_W-1:0] timerQ;
  logic [TIMER_W-1:0] loadVal;

  // Pick the delay of the phase being armed
  always_comb begin
    unique case (strb.sel)
      PH_HOLD: loadVal = holdDelay;
      PH_STOP: loadVal = stopDelay;
      default: loadVal = setupDelay;
    endcase
  end

  // Load beats decrement; saturate at zero
  always_ff @(posedge clk) begin
    if (rst) begin
      timerQ <= ZERO;
    end else if (strb.load) begin
      timerQ <= loadVal;
    end else if (timerQ != ZERO) begin
      timerQ <= timerQ - ONE;
    end
  end

  assign timerVal  = timerQ;
  assign timerZero = (timerQ == ZERO);

  AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
    strb.load |=> timerQ == $past(loadVal)); // R5

  AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (rst)
    (!strb.load && timerQ != ZERO) |=> timerQ == $past(timerQ) - ONE); // R4

  AST_HOLD_ZERO: assert property (@(posedge clk) disable iff (rst)
    (!strb.load && timerQ == ZERO) |=> timerQ == ZERO); // R4

endmodule

// File: rtl/seq_ctrl.sv
module seq_ctrl
  import seq_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        startReq,
  input  logic        timerZero,
  output seq_state_e  state,
  output logic        done,
  output timer_strb_t strb
);

  seq_state_e stateQ, stateD;
  logic       isWait;

  always_comb begin
    stateD    = stateQ;
    strb.load = 1'b0;
    strb.sel  = PH_SETUP;
    unique case (stateQ)
      ST_IDLE: begin
        if (startReq) begin
          strb.load = 1'b1;
          strb.sel  = PH_SETUP;
          stateD    = ST_WAIT_SETUP;
        end
      end
      ST_WAIT_SETUP: if (timerZero) stateD = ST_ARM_HOLD;
      ST_ARM_HOLD: begin
        strb.load = 1'b1;
        strb.sel  = PH_HOLD;
        stateD    = ST_WAIT_HOLD;
      end
      ST_WAIT_HOLD: if (timerZero) stateD = ST_ARM_STOP;
      ST_ARM_STOP: begin
        strb.load = 1'b1;
        strb.sel  = PH_STOP;
        stateD    = ST_WAIT_STOP;
      end
      ST_WAIT_STOP: if (timerZero) stateD = ST_FINISH;
      ST_FINISH:    stateD = ST_IDLE;
      default:      stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) stateQ <= ST_IDLE;
    else     stateQ <= stateD;
  end

  assign state  = stateQ;
  assign done   = (stateQ == ST_FINISH);
  assign isWait = (stateQ == ST_WAIT_SETUP) || (stateQ == ST_WAIT_HOLD) ||
                  (stateQ == ST_WAIT_STOP);

  AST_WAIT_EXIT: assert property (@(posedge clk) disable iff (rst)
    (isWait && timerZero) |=> stateQ != $past(stateQ)); // R3

  AST_WAIT_STAY: assert property (@(posedge clk) disable iff (rst)
    (isWait && !timerZero) |=> $stable(stateQ)); // R3

  AST_ARM_ONE: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_ARM_HOLD || stateQ == ST_ARM_STOP) |=> stateQ == $past(stateQ) + 3'd1); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> (!done && stateQ == ST_IDLE)); // R6

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (stateQ == ST_IDLE && !startReq) |=> stateQ == ST_IDLE); // R2

endmodule

// File: rtl/bus_phase_seq.sv
module bus_phase_seq
  import seq_pkg::*;
#(
  parameter int TIMER_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               startReq,
  input  logic [TIMER_W-1:0] setupDelay,
  input  logic [TIMER_W-1:0] holdDelay,
  input  logic [TIMER_W-1:0] stopDelay,
  output logic [2:0]         seqState,
  output logic               done,
  output logic [TIMER_W-1:0] timerVal
);

  timer_strb_t strb;
  seq_state_e  state;
  logic        timerZero;

  seq_ctrl ctrl_i (
    .clk       (clk),
    .rst       (rst),
    .startReq  (startReq),
    .timerZero (timerZero),
    .state     (state),
    .done      (done),
    .strb      (strb)
  );

  seq_timer_dp #(.TIMER_W(TIMER_W)) dp_i (
    .clk        (clk),
    .rst        (rst),
    .strb       (strb),
    .setupDelay (setupDelay),
    .holdDelay  (holdDelay),
    .stopDelay  (stopDelay),
    .timerVal   (timerVal),
    .timerZero  (timerZero)
  );

  assign seqState = state;

endmodule

// File: tb/bus_phase_seq_tb_top.sv
module bus_phase_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int TW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          startReq = 1'b0;
  logic [TW-1:0] setupDelay = '0;
  logic [TW-1:0] holdDelay = '0;
  logic [TW-1:0] stopDelay = '0;
  logic [2:0]    seqState;
  logic          done;
  logic [TW-1:0] timerVal;

  int checks = 0;
  int failures = 0;

  typedef struct {
    logic [2:0]    st;
    logic [TW-1:0] tm;
    logic          dn;
    string         req;
  } exp_t;

  exp_t expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_phase_seq #(.TIMER_W(TW)) dut_i (
    .clk(clk), .rst(rst), .startReq(startReq),
    .setupDelay(setupDelay), .holdDelay(holdDelay), .stopDelay(stopDelay),
    .seqState(seqState), .done(done), .timerVal(timerVal)
  );

  // Handshake-style model: counter in its own process, load one cycle late
  logic          hsSet = 1'b0;
  logic [TW-1:0] hsCnt = '0;
  logic [1:0]    hsSt = 2'd0;
  always @(posedge clk) begin
    if (rst) begin
      hsSet <= 1'b0; hsCnt <= '0; hsSt <= 2'd0;
    end else begin
      if (hsSet) hsCnt <= setupDelay;
      else if (hsCnt != '0) hsCnt <= hsCnt - TW'(1);
      case (hsSt)
        2'd0: if (startReq) begin hsSet <= 1'b1; hsSt <= 2'd1; end
        2'd1: begin hsSet <= 1'b0; if (hsCnt == '0) hsSt <= 2'd2; end
        default: hsSt <= 2'd0;
      endcase
    end
  end

  task automatic checkVal(string req, string what, int act, int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic push(int st, int tm, logic dn, string req);
    exp_t e;
    e.st = 3'(st); e.tm = TW'(tm); e.dn = dn; e.req = req;
    expQ.push_back(e);
  endtask

  // Driver: build full expected trace, then issue start
  task automatic runSeq(int a, int b, int c, bit disturb);
    @(negedge clk);
    setupDelay = TW'(a); holdDelay = TW'(b); stopDelay = TW'(c);
    for (int i = 0; i <= a; i++)
      push(1, a - i, 1'b0, (i == 0) ? "R2" : (disturb ? "R7" : "R3"));
    push(2, 0, 1'b0, "R5");
    for (int i = 0; i <= b; i++) push(3, b - i, 1'b0, (i == 0) ? "R5" : "R4");
    push(4, 0, 1'b0, "R5");
    for (int i = 0; i <= c; i++) push(5, c - i, 1'b0, (i == 0) ? "R5" : "R3");
    push(6, 0, 1'b1, "R6");
    push(0, 0, 1'b0, "R6");
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    if (disturb) setupDelay = TW'(a + 7);
    wait (expQ.size() == 0);
    @(negedge clk);
  endtask

  // Monitor: compare one expected item just after each edge
  always @(posedge clk) begin
    #1;
    if (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      checks++;
      if (seqState !== e.st || timerVal !== e.tm || done !== e.dn) begin
        failures++;
        $display("FAIL %s state/timer/done actual=%0d/%0d/%0d expected=%0d/%0d/%0d",
                 e.req, seqState, timerVal, done, e.st, e.tm, e.dn);
      end
    end
  end

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    failures++;
    $display("FAIL watchdog expired actual=running expected=finished");
    finishRun();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    checkVal("R1", "state", int'(seqState), 0);
    checkVal("R1", "timer", int'(timerVal), 0);
    checkVal("R1", "done", int'(done), 0);
    // R2: idle without start
    repeat (3) @(negedge clk);
    checkVal("R2", "idle state", int'(seqState), 0);

    runSeq(3, 2, 4, 1'b0);
    runSeq(0, 0, 0, 1'b0);   // R3 zero delays: one-cycle waits
    runSeq(1, 0, 2, 1'b0);
    runSeq(5, 1, 0, 1'b1);   // R7 setup input changed mid-wait
    runSeq(0, 9, 1, 1'b0);

    // R1: reset in the middle of a running sequence
    @(negedge clk);
    setupDelay = TW'(6);
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
    repeat (2) @(negedge clk);
    checkVal("R4", "mid-wait timer", int'(timerVal), 4);
    rst = 1'b1;
    @(negedge clk);
    checkVal("R1", "state after reset", int'(seqState), 0);
    checkVal("R1", "timer after reset", int'(timerVal), 0);
    rst = 1'b0;

    // R3: shared-edge load waits delay+1 cycles; handshake model exits early
    begin
      int dutWait = 0;
      int hsWait = 0;
      @(negedge clk);
      setupDelay = TW'(3); holdDelay = '0; stopDelay = '0;
      startReq = 1'b1;
      @(negedge clk);
      startReq = 1'b0;
      for (int i = 0; i < 12; i++) begin
        if (seqState == 3'd1) dutWait++;
        if (hsSt == 2'd1) hsWait++;
        @(negedge clk);
      end
      checkVal("R3", "sequencer setup wait cycles", dutWait, 4);
      checks++;
      if (!(hsWait < dutWait)) begin
        failures++;
        $display("FAIL R3 handshake wait actual=%0d expected=<%0d", hsWait, dutWait);
      end
    end
    repeat (4) @(negedge clk);
    checkVal("R6", "back in idle", int'(seqState), 0);
    finishRun();
  end

endmodule